// File: doc/BRIEF.md
# SPI Serial EEPROM Target

This block is a synthesizable SPI target that behaves like a byte-addressed serial EEPROM organised in pages. A host selects it with an active-low chip select and shifts instruction, address and data bytes in most significant bit first. It can set and clear a write-enable latch, read and write a small status register, stream reads from the array, and buffer a page write that commits only when the frame ends cleanly.

The array size (`ARRAY_AW` address bits) and page size (`PAGE_AW` bits) are parameters; the 16 KB part with 64-byte pages corresponds to `ARRAY_AW = 14`, `PAGE_AW = 6`. The default keeps a smaller array so the storage stays modest. The internal programming time is modelled by a counter of `WRITE_CYCLES` system clocks, during which a busy flag is visible in the status register. The serial pins are oversampled by the system clock, so the SPI clock must be several times slower than `clk`.

Top module: `eeprom_spi_target`

## Requirements
- R1: Bits travel most significant bit first; `mosi` is sampled on rising `sclk` edges and `miso` changes on falling edges, so clock modes 0 (idle low) and 3 (idle high) both work.
- R2: Code 0x06 sets the write-enable latch and 0x04 clears it; either takes effect only if the frame held exactly that one byte when `cs_n` rose.
- R3: Code 0x05 returns the status byte repeatedly while selected: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bit 7 status lock, other bits 0; all fields are 0 after reset.
- R4: Code 0x02, two address bytes and data bytes form a memory write; it is rejected with no array change and no busy period unless the write-enable latch is set.
- R5: A write (memory or status) is committed only if `cs_n` rises after at least one complete data byte and with no stray bits; otherwise it is discarded and the latch stays as it was.
- R6: Successive data bytes of one memory write go to successive addresses inside the same page of 2^`PAGE_AW` bytes, wrapping to the page start instead of crossing into the next page.
- R7: An accepted write keeps the busy bit at 1 for `WRITE_CYCLES` clocks, then clears both the busy bit and the write-enable latch.
- R8: While busy, only code 0x05 is honoured; every other instruction has no effect and drives no data.
- R9: Code 0x03 plus two address bytes streams bytes from an incrementing address that wraps from the last array byte to address 0; address bits at or above `ARRAY_AW` are ignored.
- R10: Code 0x01 with one data byte and the latch set loads status bits 7 and 3:2 and starts a busy period; protection level 01 blocks memory writes to the top quarter of the array, 10 the top half, 11 all of it.
- R11: A status write is rejected while status bit 7 is 1 and `wp_n` is low.
- R12: Hold starts when `hold_n` is low while `sclk` is low and ends when `hold_n` is high while `sclk` is low; during hold `miso_oe` is 0 and `sclk`/`mosi` are ignored, and the transfer resumes where it stopped.
- R13: `miso_oe` is 0 whenever `cs_n` is high, during hold, and whenever no read or status data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| wp_n | input | 1 | Active-low write protect for the status register |
| miso | output | 1 | Serial data out, valid while `miso_oe` is 1 |
| miso_oe | output | 1 | Output enable for the external tri-state driver of `miso` |

## Verification
The embedded assertions assume the serial inputs are quasi-static relative to `clk`: `cs_n` never toggles in the same system cycle as an `sclk` edge, and each `sclk` phase lasts several clocks so every edge is seen once after synchronisation. The bench keeps to that by changing pins only on falling `clk` edges and holding each `sclk` half period for six clocks, with settle gaps around chip select. It also keeps `hold_n` transitions to times when `sclk` is low, so hold entry and exit are never ambiguous.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WE,
    OP_CLR_WE,
    OP_GET_SR,
    OP_PUT_SR,
    OP_READ,
    OP_WRITE
  } op_e;

  typedef enum logic [2:0] {
    PH_CODE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_BODY,
    PH_IGNORE
  } phase_e;

  localparam logic [7:0] CODE_SET_WE = 8'h06;
  localparam logic [7:0] CODE_CLR_WE = 8'h04;
  localparam logic [7:0] CODE_GET_SR = 8'h05;
  localparam logic [7:0] CODE_PUT_SR = 8'h01;
  localparam logic [7:0] CODE_READ   = 8'h03;
  localparam logic [7:0] CODE_WRITE  = 8'h02;

  function automatic op_e decode_op(input logic [7:0] code);
    case (code)
      CODE_SET_WE: decode_op = OP_SET_WE;
      CODE_CLR_WE: decode_op = OP_CLR_WE;
      CODE_GET_SR: decode_op = OP_GET_SR;
      CODE_PUT_SR: decode_op = OP_PUT_SR;
      CODE_READ:   decode_op = OP_READ;
      CODE_WRITE:  decode_op = OP_WRITE;
      default:     decode_op = OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/sse_spi_port.sv
module sse_spi_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       hold_n,
  input  logic [7:0] tx_byte,
  input  logic       tx_en,
  output logic       sel,
  output logic       sel_start,
  output logic       sel_end,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       aligned,
  output logic       miso,
  output logic       miso_oe
);

  logic       cs_s, cs_p, sclk_s, sclk_p, mosi_s, hold_s;
  logic       hold_q, hold_d;
  logic [2:0] bit_q, bit_d;
  logic [6:0] rsh_q, rsh_d;
  logic [6:0] tsh_q, tsh_d;
  logic       out_q, out_d;
  logic       drv_q, drv_d;
  logic       edge_ok, rise, fall;

  // input sampling and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= 1'b1;
      cs_p   <= 1'b1;
      sclk_s <= 1'b0;
      sclk_p <= 1'b0;
      mosi_s <= 1'b0;
      hold_s <= 1'b1;
    end else begin
      cs_s   <= cs_n;
      cs_p   <= cs_s;
      sclk_s <= sclk;
      sclk_p <= sclk_s;
      mosi_s <= mosi;
      hold_s <= hold_n;
    end
  end

  assign sel       = !cs_s;
  assign sel_start = !cs_s && cs_p;
  assign sel_end   = cs_s && !cs_p;
  assign edge_ok   = sel && !sel_start && !hold_q;
  assign rise      = edge_ok && sclk_s && !sclk_p;
  assign fall      = edge_ok && !sclk_s && sclk_p;
  assign byte_done = rise && (bit_q == 3'd7);
  assign rx_byte   = {rsh_q, mosi_s};
  assign aligned   = (bit_q == 3'd0);
  assign miso_oe   = sel && !hold_q && drv_q;
  assign miso      = miso_oe && out_q;

  always_comb begin
    hold_d = hold_q;
    bit_d  = bit_q;
    rsh_d  = rsh_q;
    tsh_d  = tsh_q;
    out_d  = out_q;
    drv_d  = drv_q;
    if (!hold_q && !hold_s && !sclk_s) begin
      hold_d = 1'b1;
    end else if (hold_q && hold_s && !sclk_s) begin
      hold_d = 1'b0;
    end
    if (!sel || sel_start) begin
      bit_d = 3'd0;
      drv_d = 1'b0;
    end else begin
      if (rise) begin
        bit_d = bit_q + 3'd1;
        rsh_d = {rsh_q[5:0], mosi_s};
      end
      if (fall) begin
        if (bit_q == 3'd0) begin
          if (tx_en) begin
            out_d = tx_byte[7];
            tsh_d = tx_byte[6:0];
            drv_d = 1'b1;
          end else begin
            drv_d = 1'b0;
          end
        end else begin
          out_d = tsh_q[6];
          tsh_d = {tsh_q[5:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      bit_q  <= 3'd0;
      rsh_q  <= 7'd0;
      tsh_q  <= 7'd0;
      out_q  <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      bit_q  <= bit_d;
      rsh_q  <= rsh_d;
      tsh_q  <= tsh_d;
      out_q  <= out_d;
      drv_q  <= drv_d;
    end
  end

  // R13
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> !miso_oe);

  // R12
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q)) |-> ($stable(bit_q) && $stable(out_q)));

endmodule

// File: rtl/sse_store.sv
module sse_store #(
  parameter int ARRAY_AW = 11,
  parameter int PAGE_AW  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        buf_we,
  input  logic [PAGE_AW-1:0]          buf_idx,
  input  logic [7:0]                  buf_din,
  input  logic                        commit,
  input  logic [ARRAY_AW-PAGE_AW-1:0] commit_page,
  input  logic [ARRAY_AW-1:0]         rd_addr,
  output logic [7:0]                  rd_data
);

  localparam int DEPTH = 1 << ARRAY_AW;
  localparam int LANES = 1 << PAGE_AW;

  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       buf_q [LANES];
  logic [LANES-1:0] mask_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = buf_we && (buf_idx == PAGE_AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[g] <= 1'b0;
      end else if (clr) begin
        mask_q[g] <= 1'b0;
      end else if (hit) begin
        mask_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        buf_q[g] <= buf_din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < LANES; i++) begin
        if (mask_q[i]) begin
          mem_q[{commit_page, PAGE_AW'(i)}] <= buf_q[i];
        end
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R5
  commit_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (mask_q != '0));

endmodule

// File: rtl/sse_guard.sv
module sse_guard (
  input  logic [1:0] level,
  input  logic [1:0] region,
  input  logic       srwd,
  input  logic       wp_n,
  output logic       arr_lock,
  output logic       sr_lock
);

  always_comb begin
    case (level)
      2'b01:   arr_lock = (region == 2'b11);
      2'b10:   arr_lock = region[1];
      2'b11:   arr_lock = 1'b1;
      default: arr_lock = 1'b0;
    endcase
  end

  assign sr_lock = srwd && !wp_n;

endmodule

// File: rtl/eeprom_spi_target.sv
module eeprom_spi_target
  import eeprom_spi_pkg::*;
#(
  parameter int ARRAY_AW     = 11,
  parameter int PAGE_AW      = 6,
  parameter int WRITE_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic hold_n,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe
);

  localparam int HI_W  = ARRAY_AW - 8;
  localparam int PG_W  = ARRAY_AW - PAGE_AW;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic       sel, sel_start, sel_end, byte_done, aligned;
  logic [7:0] rx_byte, rd_data, status;
  logic       buf_we, commit, start, busy, arr_lock, sr_lock;
  logic [ARRAY_AW-1:0] rd_addr, full_a;

  phase_e              phase_q, phase_d;
  op_e                 op_q, op_d, dec;
  logic [HI_W-1:0]     hi_q, hi_d;
  logic [ARRAY_AW-1:0] ptr_q, ptr_d;
  logic [PAGE_AW-1:0]  idx_q, idx_d;
  logic                got_q, got_d;
  logic [7:0]          tx_q, tx_d;
  logic                txen_q, txen_d;
  logic                wel_q, wel_d;
  logic                srwd_q, srwd_d, nsrwd_q, nsrwd_d;
  logic [1:0]          bp_q, bp_d, nbp_q, nbp_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  sse_spi_port u_port (
    .clk(clk), .rst_n(rst_q), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .hold_n(hold_n), .tx_byte(tx_q), .tx_en(txen_q), .sel(sel),
    .sel_start(sel_start), .sel_end(sel_end), .byte_done(byte_done),
    .rx_byte(rx_byte), .aligned(aligned), .miso(miso), .miso_oe(miso_oe)
  );

  sse_store #(.ARRAY_AW(ARRAY_AW), .PAGE_AW(PAGE_AW)) u_store (
    .clk(clk), .rst_n(rst_q), .clr(sel_start), .buf_we(buf_we),
    .buf_idx(idx_q), .buf_din(rx_byte), .commit(commit),
    .commit_page(ptr_q[ARRAY_AW-1:PAGE_AW]), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  sse_guard u_guard (
    .level(bp_q), .region(ptr_q[ARRAY_AW-1:ARRAY_AW-2]), .srwd(srwd_q),
    .wp_n(wp_n), .arr_lock(arr_lock), .sr_lock(sr_lock)
  );

  assign busy    = (cnt_q != '0);
  assign status  = {srwd_q, 3'b000, bp_q, wel_q, busy};
  assign full_a  = {hi_q, rx_byte};
  assign rd_addr = (phase_q == PH_ADDR_LO) ? full_a : ptr_q;

  always_comb begin
    phase_d = phase_q;  op_d  = op_q;   hi_d   = hi_q;   ptr_d = ptr_q;
    idx_d   = idx_q;    got_d = got_q;  tx_d   = tx_q;   txen_d = txen_q;
    wel_d   = wel_q;    srwd_d = srwd_q; bp_d  = bp_q;
    nsrwd_d = nsrwd_q;  nbp_d = nbp_q;  cnt_d  = cnt_q;
    buf_we  = 1'b0;     commit = 1'b0;  start  = 1'b0;
    dec     = decode_op(rx_byte);
    if (busy && dec != OP_GET_SR) dec = OP_NONE;

    if (sel_start) begin
      phase_d = PH_CODE;
      op_d    = OP_NONE;
      got_d   = 1'b0;
      txen_d  = 1'b0;
    end else if (byte_done) begin
      case (phase_q)
        PH_CODE: begin
          op_d = dec;
          case (dec)
            OP_GET_SR: begin
              tx_d    = status;
              txen_d  = 1'b1;
              phase_d = PH_BODY;
            end
            OP_READ, OP_WRITE: phase_d = PH_ADDR_HI;
            OP_NONE:           phase_d = PH_IGNORE;
            default:           phase_d = PH_BODY;
          endcase
        end
        PH_ADDR_HI: begin
          hi_d    = rx_byte[HI_W-1:0];
          phase_d = PH_ADDR_LO;
        end
        PH_ADDR_LO: begin
          phase_d = PH_BODY;
          idx_d   = full_a[PAGE_AW-1:0];
          if (op_q == OP_READ) begin
            tx_d   = rd_data;
            txen_d = 1'b1;
            ptr_d  = full_a + ARRAY_AW'(1);
          end else begin
            ptr_d  = full_a;
          end
        end
        PH_BODY: begin
          case (op_q)
            OP_READ: begin
              tx_d  = rd_data;
              ptr_d = ptr_q + ARRAY_AW'(1);
            end
            OP_GET_SR: tx_d = status;
            OP_WRITE: begin
              buf_we = 1'b1;
              idx_d  = idx_q + PAGE_AW'(1);
              got_d  = 1'b1;
            end
            OP_PUT_SR: begin
              if (!got_q) begin
                nsrwd_d = rx_byte[7];
                nbp_d   = rx_byte[3:2];
              end
              got_d = 1'b1;
            end
            default: got_d = 1'b1;
          endcase
        end
        default: ;
      endcase
    end

    if (sel_end && phase_q == PH_BODY && aligned) begin
      case (op_q)
        OP_SET_WE: if (!got_q) wel_d = 1'b1;
        OP_CLR_WE: if (!got_q) wel_d = 1'b0;
        OP_WRITE: begin
          if (got_q && wel_q && !arr_lock) begin
            commit = 1'b1;
            start  = 1'b1;
          end
        end
        OP_PUT_SR: begin
          if (got_q && wel_q && !sr_lock) begin
            srwd_d = nsrwd_q;
            bp_d   = nbp_q;
            start  = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (start) begin
      cnt_d = CNT_W'(WRITE_CYCLES);
    end else if (busy) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) wel_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      phase_q <= PH_CODE;  op_q   <= OP_NONE; hi_q   <= '0;   ptr_q <= '0;
      idx_q   <= '0;       got_q  <= 1'b0;    tx_q   <= 8'd0; txen_q <= 1'b0;
      wel_q   <= 1'b0;     srwd_q <= 1'b0;    bp_q   <= 2'b00;
      nsrwd_q <= 1'b0;     nbp_q  <= 2'b00;   cnt_q  <= '0;
    end else begin
      phase_q <= phase_d;  op_q   <= op_d;    hi_q   <= hi_d;  ptr_q <= ptr_d;
      idx_q   <= idx_d;    got_q  <= got_d;   tx_q   <= tx_d;  txen_q <= txen_d;
      wel_q   <= wel_d;    srwd_q <= srwd_d;  bp_q   <= bp_d;
      nsrwd_q <= nsrwd_d;  nbp_q  <= nbp_d;   cnt_q  <= cnt_d;
    end
  end

  // R4
  busy_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(busy) |-> $past(wel_q));

  // R7
  latch_clears_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |-> !wel_q);

  // R8
  busy_status_only_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && txen_q) |-> (op_q == OP_GET_SR));

  // R10
  protected_page_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(busy) && $past(op_q == OP_WRITE)) |-> !$past(arr_lock));

  // R11
  status_lock_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(busy) && $past(op_q == OP_PUT_SR)) |-> !$past(sr_lock));

endmodule

// File: tb/eeprom_spi_target_test.sv
module eeprom_spi_target_test;

  localparam int AW   = 11;
  localparam int PW   = 6;
  localparam int WCYC = 2000;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, mosi, hold_n, wp_n;
  logic miso, miso_oe;
  logic cpol = 1'b0;
  int   checks = 0;
  int   errors = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic [7:0] model [1 << AW];

  always #2 clk = ~clk;

  eeprom_spi_target #(.ARRAY_AW(AW), .PAGE_AW(PW), .WRITE_CYCLES(WCYC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic r);
    if (cpol) sclk = 1'b0;
    mosi = b;
    tick(HALF);
    r = miso;
    sclk = 1'b1;
    tick(HALF);
    if (!cpol) sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
  endtask

  task automatic select();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic deselect();
    tick(HALF);
    cs_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic cmd1(input logic [7:0] code);
    logic [7:0] r;
    select(); xbyte(code, r); deselect();
  endtask

  task automatic get_status(output logic [7:0] s);
    logic [7:0] r;
    select(); xbyte(8'h05, r); xbyte(8'h00, s); deselect();
  endtask

  task automatic put_status(input logic [7:0] v);
    logic [7:0] r;
    select(); xbyte(8'h01, r); xbyte(v, r); deselect();
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    s = 8'h01;
    for (int i = 0; i < 40 && s[0]; i++) get_status(s);
    chk(req, {31'd0, s[0]}, 32'd0);
  endtask

  task automatic write_mem(input logic [15:0] a, input int n);
    logic [7:0] r;
    select(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], r);
    deselect();
  endtask

  task automatic model_write(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] t;
      t = a[AW-1:0];
      t[PW-1:0] = t[PW-1:0] + PW'(i);
      model[t] = wbuf[i];
    end
  endtask

  task automatic read_mem(input logic [15:0] a, input int n);
    logic [7:0] r;
    select(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
    deselect();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R13 idle output enable", {31'd0, miso_oe}, 32'd0);
    get_status(s);
    chk("R3 status after reset", {24'd0, s}, 32'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s, r;
    cmd1(8'h06); get_status(s);
    chk("R2 set latch", {24'd0, s}, 32'h02);
    cmd1(8'h04); get_status(s);
    chk("R2 clear latch", {24'd0, s}, 32'h00);
    select(); xbyte(8'h06, r); xbyte(8'h00, r); deselect();
    get_status(s);
    chk("R2 two-byte frame ignored", {24'd0, s}, 32'h00);
  endtask

  task automatic t_write_basic();
    logic [7:0] s;
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    cmd1(8'h06); write_mem(16'h0040, 4); model_write(16'h0040, 4);
    get_status(s);
    chk("R7 busy with latch during cycle", {24'd0, s}, 32'h03);
    wait_idle("R7 cycle ends");
    get_status(s);
    chk("R7 latch cleared after cycle", {24'd0, s}, 32'h00);
    read_mem(16'h0040, 4);
    for (int i = 0; i < 4; i++) chk("R1 R4 read back", {24'd0, rbuf[i]}, {24'd0, model[11'h040 + 11'(i)]});
  endtask

  task automatic t_no_latch();
    logic [7:0] s;
    wbuf[0] = 8'h55;
    write_mem(16'h0040, 1); get_status(s);
    chk("R4 no cycle without latch", {24'd0, s}, 32'h00);
    read_mem(16'h0040, 1);
    chk("R4 array unchanged", {24'd0, rbuf[0]}, {24'd0, model[11'h040]});
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hB0 + 8'(i);
    cmd1(8'h06); write_mem(16'h007E, 4); model_write(16'h007E, 4);
    wait_idle("R6 cycle ends");
    read_mem(16'h0040, 2);
    chk("R6 wrap byte 2", {24'd0, rbuf[0]}, 32'hB2);
    chk("R6 wrap byte 3", {24'd0, rbuf[1]}, 32'hB3);
    read_mem(16'h007E, 2);
    chk("R6 page end bytes", {16'd0, rbuf[0], rbuf[1]}, 32'hB0B1);
  endtask

  task automatic t_partial();
    logic [7:0] s, r;
    logic b;
    cmd1(8'h06);
    select(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r); xbyte(8'hC0, r);
    for (int i = 0; i < 3; i++) xbit(1'b1, b);
    deselect();
    get_status(s);
    chk("R5 stray bits discard", {24'd0, s}, 32'h02);
    select(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r); deselect();
    get_status(s);
    chk("R5 no data byte discard", {24'd0, s}, 32'h02);
    read_mem(16'h0040, 1);
    chk("R5 array unchanged", {24'd0, rbuf[0]}, {24'd0, model[11'h040]});
    cmd1(8'h04);
  endtask

  task automatic t_busy();
    logic [7:0] s, r;
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1;
    cmd1(8'h06); write_mem(16'h0000, 2); model_write(16'h0000, 2);
    cmd1(8'h04);
    select(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h40, r); tick(3);
    chk("R8 read ignored while busy", {31'd0, miso_oe}, 32'd0);
    deselect();
    get_status(s);
    chk("R8 clear-latch ignored while busy", {24'd0, s}, 32'h03);
    wait_idle("R8 cycle ends");
  endtask

  task automatic t_read_wrap();
    wbuf[0] = 8'hE0;
    cmd1(8'h06); write_mem(16'h07FF, 1); model_write(16'h07FF, 1);
    wait_idle("R9 cycle ends");
    wbuf[0] = 8'h77;
    cmd1(8'h06); write_mem(16'h0600, 1); model_write(16'h0600, 1);
    wait_idle("R9 cycle ends");
    read_mem(16'h07FF, 3);
    chk("R9 last byte", {24'd0, rbuf[0]}, 32'hE0);
    chk("R9 wrap to zero", {16'd0, rbuf[1], rbuf[2]}, 32'hD0D1);
    read_mem(16'h0840, 1);
    chk("R9 upper address bits ignored", {24'd0, rbuf[0]}, {24'd0, model[11'h040]});
  endtask

  task automatic t_protect();
    logic [7:0] s;
    cmd1(8'h06); put_status(8'h04);
    get_status(s);
    chk("R10 status write busy", {24'd0, s}, 32'h07);
    wait_idle("R10 cycle ends");
    get_status(s);
    chk("R10 level stored", {24'd0, s}, 32'h04);
    wbuf[0] = 8'hF0;
    cmd1(8'h06); write_mem(16'h0600, 1);
    get_status(s);
    chk("R10 top quarter rejected", {24'd0, s}, 32'h06);
    read_mem(16'h0600, 1);
    chk("R10 top quarter unchanged", {24'd0, rbuf[0]}, 32'h77);
    wbuf[0] = 8'hF1;
    write_mem(16'h0100, 1); model_write(16'h0100, 1);
    wait_idle("R10 cycle ends");
    read_mem(16'h0100, 1);
    chk("R10 lower area written", {24'd0, rbuf[0]}, 32'hF1);
    cmd1(8'h06); put_status(8'h00); wait_idle("R10 cycle ends");
  endtask

  task automatic t_sr_lock();
    logic [7:0] s;
    cmd1(8'h06); put_status(8'h80); wait_idle("R11 cycle ends");
    wp_n = 1'b0;
    cmd1(8'h06); put_status(8'h00);
    get_status(s);
    chk("R11 locked status write rejected", {24'd0, s}, 32'h82);
    wp_n = 1'b1;
    put_status(8'h00); wait_idle("R11 cycle ends");
    get_status(s);
    chk("R11 unlocked status write", {24'd0, s}, 32'h00);
  endtask

  task automatic t_hold();
    logic [7:0] r, d0, d1;
    logic b;
    select(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h40, r);
    for (int i = 7; i >= 4; i--) xbit(1'b0, d0[i]);
    hold_n = 1'b0; tick(4);
    chk("R12 output off in hold", {31'd0, miso_oe}, 32'd0);
    mosi = 1'b1;
    for (int i = 0; i < 2; i++) begin
      sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF);
    end
    hold_n = 1'b1; tick(4);
    for (int i = 3; i >= 0; i--) xbit(1'b0, d0[i]);
    xbyte(8'h00, d1);
    deselect();
    chk("R12 data across hold", {16'd0, d0, d1}, {16'd0, model[11'h040], model[11'h041]});
    b = miso_oe;
    chk("R13 off after deselect", {31'd0, b}, 32'd0);
  endtask

  task automatic t_mode3();
    logic [7:0] s;
    cpol = 1'b1; sclk = 1'b1; tick(4);
    cmd1(8'h06); get_status(s);
    chk("R1 mode 3 status", {24'd0, s}, 32'h02);
    read_mem(16'h0040, 2);
    chk("R1 mode 3 read", {16'd0, rbuf[0], rbuf[1]}, {16'd0, model[11'h040], model[11'h041]});
    cmd1(8'h04);
    cpol = 1'b0; sclk = 1'b0; tick(4);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_latch();
    t_write_basic();
    t_no_latch();
    t_wrap();
    t_partial();
    t_busy();
    t_read_wrap();
    t_protect();
    t_sr_lock();
    t_hold();
    t_mode3();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule